// File: doc/BRIEF.md
# Gapped Receive Clock and Frame Marker

This block drives the system-side timing outputs of a serial receive path. It runs on a bit-rate internal clock and, for each received bit, takes the bit value plus class flags from upstream framing logic: whether the bit is overhead or payload, whether an overhead bit is a justification-control or stuff-opportunity bit, whether it is the first bit of a frame, and whether it closes the sync window. It re-registers the data, raises a clock enable for the bits that the selected gapping policy lets through, and produces a gapped output clock from that enable through a glitch-free latch gate, plus an ungapped copy of the clock.

A second output serves either as a frame-sync pulse, spanning from the first bit of a frame to the end of the sync window, or as a payload/overhead marker. An inversion control complements both output clocks, so that a downstream circuit clocking on the edge opposite the launch edge always samples data mid-bit.

Gapping mode, marker mode and inversion are taken from the configuration inputs only on a frame's first bit and then held for the whole frame, so a reconfiguration never truncates a clock pulse.

Top module: `rx_gap_clock`

## Requirements
- R1: While `rstN` is low, `outData`, `outMark` and `gapEn` are 0, and both output clocks are low in the low phase of `clk`. After reset, the active configuration is gapping mode 0, sync-marker mode and non-inverted clocks.
- R2: `outData` equals the `bitData` value that was present at the previous rising edge of `clk`.
- R3: With gapping mode 0, or any of the spare codes 5, 6 and 7, `gapEn` is 1 for every bit.
- R4: With gapping mode 1, `gapEn` is 1 only for payload bits (`bitOvh` = 0).
- R5: With gapping mode 2, `gapEn` is 1 for payload bits and for overhead bits flagged `bitJc`.
- R6: With gapping mode 3, `gapEn` is 1 for payload bits and for overhead bits flagged `bitSo`.
- R7: With gapping mode 4, `gapEn` is 1 for payload bits and for overhead bits flagged `bitJc` or `bitSo`.
- R8: In sync-marker mode (`cfgMarkOvh` = 0), `outMark` is 1 from the bit flagged `frameStart` through the bit flagged `syncEnd`, both included, and 0 otherwise. If both flags are on the same bit, only that bit is marked.
- R9: In overhead-marker mode (`cfgMarkOvh` = 1), `outMark` is 1 on payload bits and 0 on overhead bits.
- R10: Configuration inputs are used only on a bit flagged `frameStart`; that bit and all later bits up to the next frame start use them, and configuration changes at other times have no effect.
- R11: With non-inverted clocks, `gapClk` is high in the high phase of `clk` exactly for bits whose `gapEn` is 1, and low otherwise; `fullClk` follows `clk`.
- R12: With inverted clocks, `gapClk` and `fullClk` are the complements of their non-inverted waveforms, and the inversion takes effect from the low phase before the frame's first bit is launched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate internal clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitData | input | 1 | Received bit value |
| bitOvh | input | 1 | 1 = overhead bit, 0 = payload bit |
| bitJc | input | 1 | Overhead bit is a justification-control bit |
| bitSo | input | 1 | Overhead bit is a stuff-opportunity bit |
| frameStart | input | 1 | Bit is the first bit of a frame |
| syncEnd | input | 1 | Bit is the last bit of the sync window |
| cfgGapMode | input | 3 | Gapping policy code, 0 to 4 (5 to 7 act as 0) |
| cfgMarkOvh | input | 1 | 0 = frame-sync marker, 1 = overhead marker |
| cfgInv | input | 1 | 1 = invert both output clocks |
| outData | output | 1 | Registered data bit |
| outMark | output | 1 | Frame-sync or overhead marker |
| gapEn | output | 1 | Registered gapped-clock enable |
| gapClk | output | 1 | Gapped output clock |
| fullClk | output | 1 | Ungapped output clock |

## Verification
The bench uses the default 3-bit mode field, so every policy code is reached, including the three spare codes that must fall back to ungapped. Frames are built from a fixed bit-class pattern containing payload, plain overhead, justification-control and stuff-opportunity bits, with the sync window closing a few bits into each frame. Both clock phases of every bit are sampled, so the latched gate and the negative-edge inversion register are each checked against the reference. One frame changes the configuration in mid-frame, and another places the frame start and the sync-window end on the same bit.

// File: rtl/rgc_pkg.sv
package rgc_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    GAP_ALL  = 3'd0,
    GAP_PAY  = 3'd1,
    GAP_JC   = 3'd2,
    GAP_SO   = 3'd3,
    GAP_JCSO = 3'd4
  } gap_mode_e;

  typedef struct packed {
    logic tick;
    logic mark;
    logic inv;
  } strobe_t;
endpackage

// File: rtl/rgc_ctrl.sv
module rgc_ctrl
  import rgc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitOvh,
  input  logic              bitJc,
  input  logic              bitSo,
  input  logic              frameStart,
  input  logic              syncEnd,
  input  logic [MODE_W-1:0] cfgGapMode,
  input  logic              cfgMarkOvh,
  input  logic              cfgInv,
  output strobe_t           strobe
);
  logic [MODE_W-1:0] actMode;
  logic              actMarkOvh;
  logic              actInv;
  logic              inWin;
  logic [MODE_W-1:0] effMode;
  logic              effMarkOvh;
  logic              tick;

  assign effMode    = frameStart ? cfgGapMode : actMode;
  assign effMarkOvh = frameStart ? cfgMarkOvh : actMarkOvh;

  always_comb begin
    if (!bitOvh) begin
      tick = 1'b1;
    end else begin
      case (effMode)
        GAP_PAY:  tick = 1'b0;
        GAP_JC:   tick = bitJc;
        GAP_SO:   tick = bitSo;
        GAP_JCSO: tick = bitJc | bitSo;
        default:  tick = 1'b1;
      endcase
    end
  end

  assign strobe.tick = tick;
  assign strobe.mark = effMarkOvh ? !bitOvh : (frameStart | inWin);
  assign strobe.inv  = frameStart ? cfgInv : actInv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actMode    <= GAP_ALL;
      actMarkOvh <= 1'b0;
      actInv     <= 1'b0;
      inWin      <= 1'b0;
    end else begin
      if (frameStart) begin
        actMode    <= cfgGapMode;
        actMarkOvh <= cfgMarkOvh;
        actInv     <= cfgInv;
        inWin      <= !syncEnd;
      end else if (syncEnd) begin
        inWin      <= 1'b0;
      end
    end
  end

  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> ($stable(actMode) && $stable(actMarkOvh) && $stable(actInv)));

  p_pay_only_r4: assert property (@(posedge clk) disable iff (!rstN)
    (effMode == GAP_PAY && bitOvh) |-> !strobe.tick);

  p_ovh_mark_r9: assert property (@(posedge clk) disable iff (!rstN)
    (effMarkOvh && bitOvh) |-> !strobe.mark);

  p_sync_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!effMarkOvh && frameStart) |-> strobe.mark);
endmodule

// File: rtl/rgc_datapath.sv
module rgc_datapath
  import rgc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    bitData,
  input  strobe_t strobe,
  output logic    outData,
  output logic    outMark,
  output logic    gapEn,
  output logic    gapClk,
  output logic    fullClk
);
  logic invQ;
  logic enLat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData <= 1'b0;
      outMark <= 1'b0;
      gapEn   <= 1'b0;
    end else begin
      outData <= bitData;
      outMark <= strobe.mark;
      gapEn   <= strobe.tick;
    end
  end

  // Inversion retimed to the falling edge so the output clock changes
  // polarity only while the raw clock is low.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) invQ <= 1'b0;
    else       invQ <= strobe.inv;
  end

  // Enable captured while clk is low, held through the high phase.
  always_latch begin
    if (!clk) enLat = strobe.tick & rstN;
  end

  assign gapClk  = (clk & enLat) ^ invQ;
  assign fullClk = clk ^ invQ;

  p_data_delay_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (outData == $past(bitData)));

  p_en_match_r11: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (gapEn == $past(strobe.tick)));
endmodule

// File: rtl/rx_gap_clock.sv
module rx_gap_clock
  import rgc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitData,
  input  logic              bitOvh,
  input  logic              bitJc,
  input  logic              bitSo,
  input  logic              frameStart,
  input  logic              syncEnd,
  input  logic [MODE_W-1:0] cfgGapMode,
  input  logic              cfgMarkOvh,
  input  logic              cfgInv,
  output logic              outData,
  output logic              outMark,
  output logic              gapEn,
  output logic              gapClk,
  output logic              fullClk
);
  strobe_t strobe;

  rgc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .bitOvh     (bitOvh),
    .bitJc      (bitJc),
    .bitSo      (bitSo),
    .frameStart (frameStart),
    .syncEnd    (syncEnd),
    .cfgGapMode (cfgGapMode),
    .cfgMarkOvh (cfgMarkOvh),
    .cfgInv     (cfgInv),
    .strobe     (strobe)
  );

  rgc_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .bitData (bitData),
    .strobe  (strobe),
    .outData (outData),
    .outMark (outMark),
    .gapEn   (gapEn),
    .gapClk  (gapClk),
    .fullClk (fullClk)
  );
endmodule

// File: tb/rx_gap_clock_bench.sv
module rx_gap_clock_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitData = 1'b0, bitOvh = 1'b0, bitJc = 1'b0, bitSo = 1'b0;
  logic       frameStart = 1'b0, syncEnd = 1'b0;
  logic [2:0] cfgGapMode = 3'd0;
  logic       cfgMarkOvh = 1'b0, cfgInv = 1'b0;
  logic       outData, outMark, gapEn, gapClk, fullClk;

  int passCnt = 0;
  int totalCnt = 0;
  bit finished = 0;
  string phase = "";

  // reference state
  int  mMode = 0;
  bit  mMarkOvh = 0, mInv = 0, mWin = 0;
  bit  curValid = 0;
  bit  curData, curMark, curTick, curInv;
  int  curMode;
  bit  curMarkOvh;
  int  lfsr = 32'h1ACE;

  always #10 clk = ~clk;   // 50 MHz

  rx_gap_clock u_rx_gap_clock (
    .clk(clk), .rstN(rstN), .bitData(bitData), .bitOvh(bitOvh), .bitJc(bitJc),
    .bitSo(bitSo), .frameStart(frameStart), .syncEnd(syncEnd),
    .cfgGapMode(cfgGapMode), .cfgMarkOvh(cfgMarkOvh), .cfgInv(cfgInv),
    .outData(outData), .outMark(outMark), .gapEn(gapEn), .gapClk(gapClk),
    .fullClk(fullClk)
  );

  task automatic check(string req, logic act, logic exp);
    totalCnt++;
    if (act === exp) passCnt++;
    else $display("FAIL %s %s t=%0t act=%0b exp=%0b", req, phase, $time, act, exp);
  endtask

  function automatic string modeTag(int m);
    case (m)
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      default: return "R3";
    endcase
  endfunction

  // drive one bit: wait for the edge that launches the previous bit,
  // apply the new bit, then check the previous bit's outputs
  task automatic stepBit(bit d, bit ovh, bit jc, bit so, bit fs, bit se,
                         int mode, bit mOvh, bit inv);
    int  eMode;
    bit  eMOvh, eInv, eTick, eMark;
    @(posedge clk);
    #2;
    bitData = d; bitOvh = ovh; bitJc = jc; bitSo = so;
    frameStart = fs; syncEnd = se;
    cfgGapMode = mode[2:0]; cfgMarkOvh = mOvh; cfgInv = inv;
    eMode = fs ? mode : mMode;
    eMOvh = fs ? mOvh : mMarkOvh;
    eInv  = fs ? inv : mInv;
    if (!ovh) eTick = 1;
    else if (eMode == 1) eTick = 0;
    else if (eMode == 2) eTick = jc;
    else if (eMode == 3) eTick = so;
    else if (eMode == 4) eTick = jc || so;
    else eTick = 1;
    eMark = eMOvh ? !ovh : (fs || mWin);
    if (fs) begin
      mMode = mode; mMarkOvh = mOvh; mInv = inv; mWin = !se;
    end else if (se) mWin = 0;
    #3;
    if (curValid) begin
      check("R2", outData, curData);
      check(modeTag(curMode), gapEn, curTick);
      check(curMarkOvh ? "R9" : "R8", outMark, curMark);
      check(curInv ? "R12" : "R11", gapClk, curTick ^ curInv);
      check(curInv ? "R12" : "R11", fullClk, !curInv);
    end
    #10;
    check(eInv ? "R12" : "R11", gapClk, eInv);
    check(eInv ? "R12" : "R11", fullClk, eInv);
    curValid = 1; curData = d; curTick = eTick; curMark = eMark;
    curInv = eInv; curMode = eMode; curMarkOvh = eMOvh;
  endtask

  function automatic bit nextBit();
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
    return lfsr[0];
  endfunction

  // frame: bit 0 start, sync window ends at seAt; class pattern repeats per 8
  task automatic runFrame(int mode, bit mOvh, bit inv, int len, int seAt);
    for (int i = 0; i < len; i++) begin
      bit ovh = (i % 4 == 0) || (i % 8 == 5);
      bit jc  = (i % 8 == 0);
      bit so  = (i % 8 == 4);
      stepBit(nextBit(), ovh, jc, so, i == 0, i == seAt, mode, mOvh, inv);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      totalCnt++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", passCnt, totalCnt);
      $finish;
    end
  end

  initial begin
    phase = "reset";
    repeat (3) @(posedge clk);
    #15;
    check("R1", outData, 1'b0);
    check("R1", outMark, 1'b0);
    check("R1", gapEn, 1'b0);
    check("R1", gapClk, 1'b0);
    check("R1", fullClk, 1'b0);
    rstN = 1'b1;
    phase = "defaults";
    // no frame start yet: reset configuration (mode 0, sync, non-inverted)
    for (int i = 0; i < 8; i++)
      stepBit(nextBit(), i % 2 == 0, i == 2, i == 4, 0, 0, 1, 1, 1);
    phase = "modes";
    for (int m = 0; m < 8; m++) runFrame(m, 0, 0, 16, 3);
    phase = "overhead marker";
    runFrame(4, 1, 0, 16, 2);
    runFrame(1, 1, 0, 16, 2);
    phase = "inverted";
    runFrame(2, 0, 1, 16, 3);
    runFrame(3, 1, 1, 16, 3);
    phase = "start and end together";
    runFrame(1, 0, 0, 12, 0);
    phase = "R10 cfg change mid-frame";
    stepBit(1, 0, 0, 0, 1, 0, 1, 0, 0);
    for (int i = 1; i < 12; i++)
      stepBit(nextBit(), i % 3 == 0, i % 6 == 0, i % 6 == 3, 0, i == 4, 0, 1, 1);
    phase = "after R10";
    runFrame(0, 0, 0, 8, 2);
    stepBit(0, 0, 0, 0, 0, 0, 0, 0, 0);
    finished = 1;
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end
endmodule